// File: doc/BRIEF.md
# Length-Bounded Pseudo-Random Stream Source

This block fills a 32-bit AXI4-Stream master with pseudo-random words from a 32-bit Fibonacci-style shift-register generator. A transfer is described by a seed and a length counted in bytes. A start request launches it. The request can come from dedicated input pins or from a small write-only register port. The block then emits exactly the requested number of bytes and stops.

Each beat carries the current generator word, least significant byte first. After each accepted beat the generator moves on by 32 bits. It does so in two 16-bit steps whose feedback taps sit at bit positions 32, 30, 26 and 25. The length need not be a multiple of four. The final beat therefore carries a computed byte-keep mask and the only last-beat marker of the transfer, so a downstream memory writer closes its buffer at the right byte. Backpressure from the sink stalls the block without loss.

Top module: `lfsr_stream_src`

## Requirements
- R1: After reset, tvalid, tlast and busy are low.
- R2: The first beat's tdata equals the seed. Bits 7:0 carry the first byte. Each later beat's tdata is the previous word advanced twice by one 16-bit step. One step computes f = ((s>>16)^(s>>14)^(s>>10)^(s>>9)) & 0xFFFF and yields ((s<<16)|f) mod 2^32.
- R3: A start with a zero seed uses the parameter value DefaultSeed (32'hACE1_2468 by default) as the first word.
- R4: tkeep is 4'b1111 on every beat except a final beat that carries 1, 2 or 3 bytes. That final beat shows 4'b0001, 4'b0011 or 4'b0111 respectively.
- R5: A transfer of L bytes has exactly ceil(L/4) beats. tlast is high on the final one only, and the keep bits over the transfer add up to L.
- R6: While tvalid is high and tready is low, tdata, tkeep and tlast hold and tvalid stays high. The stream advances only on a cycle where both are high.
- R7: busy and tvalid rise in the cycle after an accepted start. They stay high until the cycle after the tlast beat handshakes.
- R8: A start request, from either source, is ignored while busy is high. This includes the cycle of the final handshake.
- R9: A start with a byte length of zero produces no beat, and busy stays low.
- R10: On the register port, a write to byte address 0 stores the seed. A write to address 4 stores the length from data bits 25:0. A write to address 8 with data bit 0 set starts a transfer from the stored values. Writes to 0 or 4 during a transfer do not alter it.
- R11: If the pin start and a register start arrive in the same cycle, the pin start wins and uses seedIn and lenIn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Pin start request, one cycle |
| seedIn | input | 32 | Seed for a pin start |
| lenIn | input | 26 | Byte length for a pin start |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register byte address |
| regWrData | input | 32 | Register write data |
| mAxisTvalid | output | 1 | Stream beat valid |
| mAxisTready | input | 1 | Stream sink ready |
| mAxisTdata | output | 32 | Stream data word |
| mAxisTkeep | output | 4 | Byte-keep mask |
| mAxisTlast | output | 1 | Final beat marker |
| busy | output | 1 | Transfer in progress |

## Verification
A new start request can coincide with the handshake of the final beat. In that cycle the control is still busy, so the request must be dropped rather than merged into the end of the running transfer. The bench provokes this on purpose by pulsing the pin start exactly when a beat with tlast is presented and tready is high. Its cycle model expects the block to go idle on the next cycle with no new beat. The same-cycle arrival of a pin start and a register start is provoked as well, and the model expects the pin's seed and length to be used.

// File: rtl/lfsr_stream_pkg.sv
package lfsr_stream_pkg;

  localparam int WordBits  = 32;
  localparam int LaneCount = WordBits / 8;

  typedef struct packed {
    logic load;     // take a new seed
    logic advance;  // beat accepted, move generator on
  } strobeT;

  // one 16-bit step of the generator
  function automatic logic [WordBits-1:0] halfStep(input logic [WordBits-1:0] s);
    logic [15:0] fb;
    fb = s[31:16] ^ s[29:14] ^ s[25:10] ^ s[24:9];
    return {s[15:0], fb};
  endfunction

endpackage

// File: rtl/lfsr_stream_cfg.sv
module lfsr_stream_cfg
  import lfsr_stream_pkg::*;
#(
  parameter int LenWidth  = 26,
  parameter int AddrWidth = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [WordBits-1:0]  seedIn,
  input  logic [LenWidth-1:0]  lenIn,
  input  logic                 regWrEn,
  input  logic [AddrWidth-1:0] regAddr,
  input  logic [WordBits-1:0]  regWrData,
  output logic                 startReq,
  output logic [WordBits-1:0]  reqSeed,
  output logic [LenWidth-1:0]  reqLen
);

  localparam logic [AddrWidth-1:0] SeedOffset = AddrWidth'(0);
  localparam logic [AddrWidth-1:0] LenOffset  = AddrWidth'(4);
  localparam logic [AddrWidth-1:0] GoOffset   = AddrWidth'(8);

  logic [WordBits-1:0] seedReg;
  logic [LenWidth-1:0] lenReg;
  logic                regStart;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seedReg <= '0;
      lenReg  <= '0;
    end else if (regWrEn) begin
      if (regAddr == SeedOffset) seedReg <= regWrData;
      if (regAddr == LenOffset)  lenReg  <= regWrData[LenWidth-1:0];
    end
  end

  assign regStart = regWrEn && (regAddr == GoOffset) && regWrData[0];

  // pin start takes priority over a register start
  always_comb begin
    startReq = startIn || regStart;
    if (startIn) begin
      reqSeed = seedIn;
      reqLen  = lenIn;
    end else begin
      reqSeed = seedReg;
      reqLen  = lenReg;
    end
  end

endmodule

// File: rtl/lfsr_stream_ctrl.sv
module lfsr_stream_ctrl
  import lfsr_stream_pkg::*;
#(
  parameter int LenWidth = 26
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [LenWidth-1:0]  reqLen,
  input  logic                 ready,
  output logic                 valid,
  output logic                 last,
  output logic [LaneCount-1:0] keep,
  output logic                 busy,
  output strobeT               strobe
);

  localparam logic [LenWidth-1:0] LaneBytes = LenWidth'(LaneCount);

  logic                busyR;
  logic [LenWidth-1:0] remaining;
  logic                finalBeat;

  assign finalBeat      = remaining <= LaneBytes;
  assign strobe.load    = startReq && !busyR && (reqLen != '0);
  assign strobe.advance = busyR && ready;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR     <= 1'b0;
      remaining <= '0;
    end else if (strobe.load) begin
      busyR     <= 1'b1;
      remaining <= reqLen;
    end else if (strobe.advance) begin
      if (finalBeat) begin
        busyR     <= 1'b0;
        remaining <= '0;
      end else begin
        remaining <= remaining - LaneBytes;
      end
    end
  end

  // lane i is kept when more than i bytes remain
  for (genvar lane = 0; lane < LaneCount; lane++) begin : gKeep
    assign keep[lane] = busyR && (remaining > LenWidth'(lane));
  end

  assign valid = busyR;
  assign busy  = busyR;
  assign last  = busyR && finalBeat;

endmodule

// File: rtl/lfsr_stream_dp.sv
module lfsr_stream_dp
  import lfsr_stream_pkg::*;
#(
  parameter logic [WordBits-1:0] DefaultSeed = 32'hACE1_2468
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [WordBits-1:0] reqSeed,
  output logic [WordBits-1:0] word
);

  logic [WordBits-1:0] state;
  logic [WordBits-1:0] seedFixed;

  assign seedFixed = (reqSeed == '0) ? DefaultSeed : reqSeed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= DefaultSeed;
    end else if (strobe.load) begin
      state <= seedFixed;
    end else if (strobe.advance) begin
      state <= halfStep(halfStep(state));
    end
  end

  assign word = state;

endmodule

// File: rtl/lfsr_stream_src.sv
module lfsr_stream_src
  import lfsr_stream_pkg::*;
#(
  parameter int                  LenWidth    = 26,
  parameter int                  AddrWidth   = 4,
  parameter logic [WordBits-1:0] DefaultSeed = 32'hACE1_2468
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [WordBits-1:0]  seedIn,
  input  logic [LenWidth-1:0]  lenIn,
  input  logic                 regWrEn,
  input  logic [AddrWidth-1:0] regAddr,
  input  logic [WordBits-1:0]  regWrData,
  output logic                 mAxisTvalid,
  input  logic                 mAxisTready,
  output logic [WordBits-1:0]  mAxisTdata,
  output logic [LaneCount-1:0] mAxisTkeep,
  output logic                 mAxisTlast,
  output logic                 busy
);

  logic                startReq;
  logic [WordBits-1:0] reqSeed;
  logic [LenWidth-1:0] reqLen;
  strobeT              strobe;

  lfsr_stream_cfg #(.LenWidth(LenWidth), .AddrWidth(AddrWidth)) uCfg (
    .clk(clk), .rstN(rstN),
    .startIn(startIn), .seedIn(seedIn), .lenIn(lenIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .startReq(startReq), .reqSeed(reqSeed), .reqLen(reqLen)
  );

  lfsr_stream_ctrl #(.LenWidth(LenWidth)) uCtrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .reqLen(reqLen), .ready(mAxisTready),
    .valid(mAxisTvalid), .last(mAxisTlast), .keep(mAxisTkeep),
    .busy(busy), .strobe(strobe)
  );

  lfsr_stream_dp #(.DefaultSeed(DefaultSeed)) uDp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .reqSeed(reqSeed), .word(mAxisTdata)
  );

endmodule

// File: rtl/lfsr_stream_checker.sv
module lfsr_stream_checker (
  input logic        clk,
  input logic        rstN,
  input logic        tvalid,
  input logic        tready,
  input logic [31:0] tdata,
  input logic [3:0]  tkeep,
  input logic        tlast,
  input logic        busy
);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    tvalid && !tready |=> tvalid && $stable(tdata) && $stable(tkeep) && $stable(tlast));

  assert_last_needs_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    tlast |-> tvalid);

  assert_full_keep_midstream_R4: assert property (@(posedge clk) disable iff (!rstN)
    tvalid && !tlast |-> tkeep == 4'b1111);

  assert_keep_low_contiguous_R4: assert property (@(posedge clk) disable iff (!rstN)
    tvalid |-> tkeep[0] && $onehot0({1'b0, tkeep} + 5'd1));

  assert_busy_until_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy && !(tvalid && tready && tlast) |=> busy);

  assert_idle_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    tvalid && tready && tlast |=> !busy);

  assert_word_nonzero_R3: assert property (@(posedge clk) disable iff (!rstN)
    tvalid |-> tdata != 32'h0);

endmodule

bind lfsr_stream_src lfsr_stream_checker uChk (
  .clk(clk), .rstN(rstN),
  .tvalid(mAxisTvalid), .tready(mAxisTready), .tdata(mAxisTdata),
  .tkeep(mAxisTkeep), .tlast(mAxisTlast), .busy(busy)
);

// File: tb/tb_lfsr_stream_src.sv
module tb_lfsr_stream_src;

  localparam logic [31:0] DefSeed = 32'hACE1_2468;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic [31:0] seedIn = '0;
  logic [25:0] lenIn = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        mAxisTvalid, mAxisTready, mAxisTlast, busy;
  logic [31:0] mAxisTdata;
  logic [3:0]  mAxisTkeep;

  always #4 clk = ~clk;

  lfsr_stream_src dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .seedIn(seedIn), .lenIn(lenIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .mAxisTvalid(mAxisTvalid), .mAxisTready(mAxisTready), .mAxisTdata(mAxisTdata),
    .mAxisTkeep(mAxisTkeep), .mAxisTlast(mAxisTlast), .busy(busy)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural model
  bit        mBusy = 0;
  int        mRem = 0;
  bit [31:0] mWord = 0;
  bit [31:0] mSeedReg = 0;
  int        mLenReg = 0;
  int        curLen = 0;
  int        byteSum = 0;

  function automatic bit [31:0] step16(bit [31:0] s);
    bit [31:0] f;
    f = ((s >> 16) ^ (s >> 14) ^ (s >> 10) ^ (s >> 9)) & 32'hFFFF;
    return (s << 16) | f;
  endfunction

  function automatic bit [3:0] keepFor(int r);
    if (r >= 4) return 4'b1111;
    return 4'((1 << r) - 1);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit ds, bit [31:0] dSeed, int dLen, bit rdy,
                     bit we, bit [3:0] wa, bit [31:0] wd);
    bit regGo;
    bit go;
    bit [31:0] sSeed;
    int sLen;
    @(negedge clk);
    check("R7", "tvalid", 32'(mAxisTvalid), 32'(mBusy));
    check("R7", "busy", 32'(busy), 32'(mBusy));
    if (mBusy) begin
      check("R2", "tdata", mAxisTdata, mWord);
      check("R4", "tkeep", 32'(mAxisTkeep), 32'(keepFor(mRem)));
      check("R5", "tlast", 32'(mAxisTlast), 32'(mRem <= 4));
    end else begin
      check("R5", "tlast idle", 32'(mAxisTlast), 32'h0);
    end
    startIn = ds; seedIn = dSeed; lenIn = 26'(dLen); mAxisTready = rdy;
    regWrEn = we; regAddr = wa; regWrData = wd;
    // model next state
    regGo = we && wa == 4'h8 && wd[0];
    if (mBusy) begin
      if (rdy) begin
        byteSum += $countones(mAxisTkeep);
        if (mRem <= 4) begin
          check("R5", "bytes in transfer", 32'(byteSum), 32'(curLen));
          mBusy = 0;
          mRem = 0;
        end else begin
          mRem -= 4;
          mWord = step16(step16(mWord));
        end
      end
    end else begin
      go = ds || regGo;
      sSeed = ds ? dSeed : mSeedReg;
      sLen  = ds ? dLen : mLenReg;
      if (go && sLen != 0) begin
        mBusy = 1;
        mRem = sLen;
        curLen = sLen;
        byteSum = 0;
        mWord = (sSeed == 0) ? DefSeed : sSeed;
      end
    end
    if (we && wa == 4'h0) mSeedReg = wd;
    if (we && wa == 4'h4) mLenReg = int'(wd[25:0]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic pinStart(bit [31:0] s, int l);
    cyc(1, s, l, 1, 0, 0, 0);
  endtask

  task automatic regWrite(bit [3:0] a, bit [31:0] d);
    cyc(0, 0, 0, 1, 1, a, d);
  endtask

  // pattern 0: always ready, 1: stall one cycle in three, 2: stall two in three
  task automatic drain(int pat);
    int k = 0;
    while (mBusy && k < 1000) begin
      cyc(0, 0, 0, pat == 0 ? 1'b1 : (pat == 1 ? (k % 3 != 1) : (k % 3 == 2)), 0, 0, 0);
      k++;
    end
  endtask

  initial begin
    mAxisTready = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    @(posedge clk);
    #1;
    check("R1", "tvalid after reset", 32'(mAxisTvalid), 0);
    check("R1", "tlast after reset", 32'(mAxisTlast), 0);
    check("R1", "busy after reset", 32'(busy), 0);
    idle(2);

    // R2 R4 R5 partial final beat
    pinStart(32'h1234_5678, 13); drain(0); idle(2);
    // R6 backpressure, exact multiple
    pinStart(32'hDEAD_BEEF, 16); drain(1); idle(1);
    pinStart(32'h0F0F_1234, 30); drain(2); idle(1);
    // R4 short lengths
    pinStart(32'h0000_0001, 1); drain(0); idle(1);
    pinStart(32'h8000_0000, 2); drain(1); idle(1);
    pinStart(32'h5555_AAAA, 3); drain(2); idle(1);
    pinStart(32'h7777_0001, 4); drain(0); idle(1);
    // R9 zero length
    pinStart(32'h1111_1111, 0); idle(3);
    // R3 zero seed
    pinStart(32'h0, 9); drain(1); idle(1);
    // R8 start while busy, mid transfer and at the final handshake
    pinStart(32'hCAFE_0001, 8);
    cyc(1, 32'h9999_0000, 40, 1, 0, 0, 0);
    cyc(1, 32'h4444_0000, 20, 1, 1, 4'h8, 32'h1);
    idle(3);
    pinStart(32'hCAFE_0002, 12);
    cyc(0, 0, 0, 0, 1, 4'h8, 32'h1);
    drain(1); idle(1);
    // R10 register port
    regWrite(4'h0, 32'hB00C_1E55);
    regWrite(4'h4, 32'hFC00_000B);   // upper bits dropped, length 11
    regWrite(4'h8, 32'h0);           // bit 0 clear, no start
    idle(2);
    regWrite(4'h8, 32'h1);
    regWrite(4'h0, 32'h2222_3333);   // during transfer
    regWrite(4'h4, 32'd5);
    drain(1); idle(1);
    regWrite(4'h8, 32'h3);
    drain(0); idle(1);
    // R11 both sources in one cycle
    cyc(1, 32'h6789_ABCD, 7, 1, 1, 4'h8, 32'h1);
    drain(0); idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule